// File: doc/BRIEF.md
# Bus Arbitration Controller

This block decides when a processor hands its external bus to another master. It accepts a bus request and a grant acknowledge, both active-low and arriving with no timing relation to the clock. Each passes through a two-stage synchronizer. A single state machine then drives an active-low bus grant and an active-high three-state control. When the three-state control is true, the processor's pad logic floats the address, data and control lines after address strobe has gone away. A busy-hold output tells the bus-cycle sequencer not to start a new cycle while the bus is given away.

A mode input selects one of two arbitration schemes. The three-wire scheme uses request, grant and acknowledge. The two-wire scheme uses only request and grant: the acknowledge is masked off inside the block, and the machine then only moves among idle, deferred and granted. The sequencer reports three events: a cycle has started, address strobe is now asserted, and the cycle is complete. From these the block tracks the narrow window between the start of a cycle and the assertion of address strobe. A request that is first seen inside that window has its grant pushed back by one clock. Arbitration runs the same way whether the bus is busy or idle.

Top module: `busarb_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, bus_grant_n is 1, bus_float is 0 and seq_hold is 0.
- R2: Each asynchronous input passes through two rising-edge flops. With the window closed and the machine idle, bus_grant_n falls on the third rising edge after bus_req_n is driven low, not earlier.
- R3: A request first seen while the window is open makes bus_grant_n fall on the fourth rising edge after bus_req_n goes low, one edge later than in R2.
- R4: In three-wire mode (wire2_mode = 0), once the grant is out, driving bus_ack_n low makes bus_grant_n return to 1 on the third rising edge after it, while bus_float stays 1.
- R5: In three-wire mode, bus_float falls on the third edge after both bus_ack_n and bus_req_n are driven high. If bus_ack_n goes high while bus_req_n stays low, the grant is given again on the third edge.
- R6: In two-wire mode (wire2_mode = 1), bus_ack_n has no effect. The grant holds for as long as the request does. bus_grant_n returns to 1 and bus_float to 0 on the third edge after bus_req_n goes high.
- R7: seq_hold is 1 exactly when bus_float is 1, and both are 1 whenever bus_grant_n is 0.
- R8: The window opens on the edge that samples seq_cyc_start = 1. It closes on the edge that samples seq_strobe_on = 1 or seq_cyc_done = 1; a close wins over an open in the same cycle. A request after the window closes gets the R2 timing.
- R9: If the request is withdrawn during the deferred clock of R3, no grant is given and the machine returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wire2_mode | input | 1 | 1 selects two-wire arbitration, 0 selects three-wire |
| bus_req_n | input | 1 | Asynchronous bus request from another master, active low |
| bus_ack_n | input | 1 | Asynchronous grant acknowledge, active low |
| seq_cyc_start | input | 1 | Sequencer: a bus cycle has started |
| seq_strobe_on | input | 1 | Sequencer: address strobe is now asserted |
| seq_cyc_done | input | 1 | Sequencer: the bus cycle is complete |
| bus_grant_n | output | 1 | Bus grant, active low |
| bus_float | output | 1 | Three-state control for address, data and control buses |
| seq_hold | output | 1 | Tells the sequencer not to start a new cycle |

## Verification
Directed sequences count edges from each pin change. A request with the window closed tells the normal three-edge grant apart from the deferred four-edge one, and a request after address strobe shows that the window has closed. A request that lasts only one cycle inside the window checks that a withdrawn request is dropped during the extra clock. In three-wire mode, acknowledge with the request held and then acknowledge released separate re-granting from full release. In two-wire mode, a toggling acknowledge must change nothing. Long runs of seeded random pin and sequencer activity in both modes are then compared each cycle with a bench model of the arbitration rules, which exercises requests that overlap window edges and acknowledges that race requests.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_DEFER = 2'd1,
    ARB_GRANT = 2'd2,
    ARB_OWNED = 2'd3
  } arb_state_e;

  // Next state from synchronized request r, effective acknowledge a and window flag w
  function automatic arb_state_e arb_next(arb_state_e st, logic r, logic a, logic w);
    arb_state_e nx;
    nx = st;
    case (st)
      ARB_IDLE:  if (r) nx = w ? ARB_DEFER : ARB_GRANT;
      ARB_DEFER: nx = r ? ARB_GRANT : ARB_IDLE;
      ARB_GRANT: begin
        if (a)       nx = ARB_OWNED;
        else if (!r) nx = ARB_IDLE;
      end
      ARB_OWNED: if (!a) nx = r ? ARB_GRANT : ARB_IDLE;
      default:   nx = ARB_IDLE;
    endcase
    return nx;
  endfunction

  function automatic logic arb_grants(arb_state_e st);
    return st == ARB_GRANT;
  endfunction

  function automatic logic arb_floats(arb_state_e st);
    return (st == ARB_GRANT) || (st == ARB_OWNED);
  endfunction

  // Window: close wins over open
  function automatic logic win_next(logic cur, logic open_ev, logic close_ev);
    if (close_ev) return 1'b0;
    if (open_ev)  return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_first,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end
  endgenerate

  assign q_first = chain[0];
  assign q_sync  = chain[STAGES-1];
endmodule

// File: rtl/busarb_phase.sv
module busarb_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic strobe_on,
  input  logic cyc_done,
  output logic window
);
  import busarb_pkg::*;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) window <= 1'b0;
    else        window <= win_next(window, cyc_start, strobe_on | cyc_done);
endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  input  logic window,
  output logic grant,
  output logic float_ctl,
  output logic is_idle
);
  import busarb_pkg::*;

  arb_state_e state;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ARB_IDLE;
    else        state <= arb_next(state, req, ack, window);

  assign grant     = arb_grants(state);
  assign float_ctl = arb_floats(state);
  assign is_idle   = (state == ARB_IDLE);
endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wire2_mode,
  input  logic bus_req_n,
  input  logic bus_ack_n,
  input  logic seq_cyc_start,
  input  logic seq_strobe_on,
  input  logic seq_cyc_done,
  output logic bus_grant_n,
  output logic bus_float,
  output logic seq_hold
);
  logic req_m, req_s, ack_m, ack_s, ack_eff;
  logic win_q, grant_int, float_int, st_idle;

  busarb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_async(~bus_req_n), .q_first(req_m), .q_sync(req_s));

  busarb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_async(~bus_ack_n), .q_first(ack_m), .q_sync(ack_s));

  // two-wire mode masks the acknowledge off
  assign ack_eff = ack_s & ~wire2_mode;

  busarb_phase u_phase (
    .clk(clk), .rst_n(rst_n), .cyc_start(seq_cyc_start),
    .strobe_on(seq_strobe_on), .cyc_done(seq_cyc_done), .window(win_q));

  busarb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req_s), .ack(ack_eff), .window(win_q),
    .grant(grant_int), .float_ctl(float_int), .is_idle(st_idle));

  assign bus_grant_n = ~grant_int;
  assign bus_float   = float_int;
  assign seq_hold    = float_int;

  logic unused_ack_m;
  assign unused_ack_m = ack_m;
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk (
  input logic clk,
  input logic rst_n,
  input logic wire2_mode,
  input logic req_m,
  input logic req_s,
  input logic ack_eff,
  input logic win_q,
  input logic st_idle,
  input logic bus_grant_n,
  input logic bus_float,
  input logic seq_hold
);
  always @(posedge clk)
    if (!rst_n) begin
      // R1
      reset_state_chk: assert (bus_grant_n && !bus_float && !seq_hold);
    end

  // R2
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_s) |-> $past(req_m));

  // R3
  defer_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && req_s && win_q) |=> bus_grant_n);

  // R4
  ack_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wire2_mode && !bus_grant_n && ack_eff) |=> (bus_grant_n && bus_float));

  // R5
  release_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_float) |-> (!$past(req_s) && !$past(ack_eff)));

  // R6
  two_wire_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wire2_mode && !bus_grant_n && !req_s) |=> (bus_grant_n && !bus_float));

  // R7
  grant_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> (bus_float && seq_hold));
endmodule

bind busarb_ctrl busarb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wire2_mode(wire2_mode), .req_m(req_m), .req_s(req_s),
  .ack_eff(ack_eff), .win_q(win_q), .st_idle(st_idle), .bus_grant_n(bus_grant_n),
  .bus_float(bus_float), .seq_hold(seq_hold));

// File: tb/busarb_ctrl_bench.sv
`timescale 1ns/1ps
module busarb_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wire2_mode = 1'b0, bus_req_n = 1'b1, bus_ack_n = 1'b1;
  logic seq_cyc_start = 1'b0, seq_strobe_on = 1'b0, seq_cyc_done = 1'b0;
  logic bus_grant_n, bus_float, seq_hold;
  int checks = 0, errors = 0;
  bit done = 0, cmp_en = 0;

  always #4 clk = ~clk;

  busarb_ctrl u_busarb_ctrl (.*);

  // bench model: state codes 0 idle, 1 deferred, 2 granted, 3 other master owns bus
  int m_st;
  logic [1:0] m_req, m_ack;
  logic m_win;

  function automatic int model_next(int st, bit r, bit a, bit w);
    if (st == 0) return r ? (w ? 1 : 2) : 0;
    if (st == 1) return r ? 2 : 0;
    if (st == 2) return a ? 3 : (r ? 2 : 0);
    return a ? 3 : (r ? 2 : 0);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_st <= 0; m_req <= 2'b00; m_ack <= 2'b00; m_win <= 1'b0;
    end else begin
      m_st  <= model_next(m_st, m_req[1], m_ack[1] & ~wire2_mode, m_win);
      m_req <= {m_req[0], ~bus_req_n};
      m_ack <= {m_ack[0], ~bus_ack_n};
      m_win <= (seq_strobe_on | seq_cyc_done) ? 1'b0 : (seq_cyc_start ? 1'b1 : m_win);
    end

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic clear_pins();
    bus_req_n = 1'b1; bus_ack_n = 1'b1;
    seq_cyc_start = 1'b0; seq_strobe_on = 1'b0; seq_cyc_done = 1'b0;
    step(6);
  endtask

  task automatic do_reset(bit mode);
    rst_n = 1'b0; wire2_mode = mode;
    bus_req_n = 1'b1; bus_ack_n = 1'b1;
    seq_cyc_start = 1'b0; seq_strobe_on = 1'b0; seq_cyc_done = 1'b0;
    step(3);
    chk("R1 grant in reset", bus_grant_n, 1'b1);
    chk("R1 float in reset", bus_float, 1'b0);
    chk("R1 hold in reset", seq_hold, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1 grant after reset", bus_grant_n, 1'b1);
  endtask

  // per-cycle model comparison during the random phase
  always @(negedge clk)
    if (cmp_en && rst_n) begin
      chk(wire2_mode ? "R6 grant vs model" : "R4 grant vs model", bus_grant_n, !(m_st == 2));
      chk(wire2_mode ? "R6 float vs model" : "R5 float vs model", bus_float, (m_st == 2 || m_st == 3));
      chk("R7 hold vs float", seq_hold, bus_float);
    end

  task automatic random_run(int n);
    cmp_en = 1;
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(7) == 0) bus_req_n = ~bus_req_n;
      if ($urandom_range(7) == 0) bus_ack_n = ~bus_ack_n;
      seq_cyc_start = ($urandom_range(9) == 0);
      seq_strobe_on = ($urandom_range(9) == 0);
      seq_cyc_done  = ($urandom_range(15) == 0);
      step(1);
    end
    cmp_en = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // three-wire directed
    do_reset(1'b0);
    bus_req_n = 1'b0;
    step(2); chk("R2 no grant after two edges", bus_grant_n, 1'b1);
    step(1); chk("R2 grant on third edge", bus_grant_n, 1'b0);
    chk("R7 float while granted", bus_float, 1'b1);
    chk("R7 hold while granted", seq_hold, 1'b1);
    bus_ack_n = 1'b0;
    step(2); chk("R4 grant held two edges after ack", bus_grant_n, 1'b0);
    step(1); chk("R4 grant drops on third edge", bus_grant_n, 1'b1);
    chk("R4 float stays", bus_float, 1'b1);
    bus_ack_n = 1'b1;
    step(3); chk("R5 regrant with request pending", bus_grant_n, 1'b0);
    bus_ack_n = 1'b0;
    step(3); chk("R4 ack again", bus_grant_n, 1'b1);
    bus_ack_n = 1'b1; bus_req_n = 1'b1;
    step(2); chk("R5 float held two edges", bus_float, 1'b1);
    step(1); chk("R5 float released on third edge", bus_float, 1'b0);
    chk("R5 grant negated", bus_grant_n, 1'b1);
    clear_pins();

    // window defer
    seq_cyc_start = 1'b1; step(1);
    seq_cyc_start = 1'b0; bus_req_n = 1'b0;
    step(3); chk("R3 no grant on third edge in window", bus_grant_n, 1'b1);
    step(1); chk("R3 grant on fourth edge", bus_grant_n, 1'b0);
    seq_strobe_on = 1'b1; step(1); seq_strobe_on = 1'b0;
    clear_pins();

    // window closed by strobe: normal timing
    seq_cyc_start = 1'b1; step(1);
    seq_cyc_start = 1'b0; seq_strobe_on = 1'b1; step(1);
    seq_strobe_on = 1'b0; bus_req_n = 1'b0;
    step(3); chk("R8 closed window gives third-edge grant", bus_grant_n, 1'b0);
    clear_pins();

    // open and close in same cycle: close wins
    seq_cyc_start = 1'b1; seq_cyc_done = 1'b1; step(1);
    seq_cyc_start = 1'b0; seq_cyc_done = 1'b0; bus_req_n = 1'b0;
    step(3); chk("R8 close wins over open", bus_grant_n, 1'b0);
    clear_pins();

    // withdrawn during deferral
    seq_cyc_start = 1'b1; step(1);
    seq_cyc_start = 1'b0; bus_req_n = 1'b0; step(1);
    bus_req_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(1); chk("R9 withdrawn request not granted", bus_grant_n, 1'b1);
    end
    chk("R9 float stays low", bus_float, 1'b0);
    seq_cyc_done = 1'b1; step(1); seq_cyc_done = 1'b0;
    clear_pins();

    // two-wire directed
    do_reset(1'b1);
    bus_req_n = 1'b0; bus_ack_n = 1'b0;
    step(3); chk("R6 grant on third edge", bus_grant_n, 1'b0);
    for (int k = 0; k < 5; k++) begin
      bus_ack_n = ~bus_ack_n;
      step(1); chk("R6 ack ignored", bus_grant_n, 1'b0);
    end
    bus_req_n = 1'b1;
    step(2); chk("R6 grant held two edges", bus_grant_n, 1'b0);
    step(1); chk("R6 grant released on third edge", bus_grant_n, 1'b1);
    chk("R6 float released", bus_float, 1'b0);
    clear_pins();

    // random phases
    do_reset(1'b0);
    random_run(4000);
    do_reset(1'b1);
    random_run(4000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule